// File: doc/BRIEF.md
# Serial DAC Word Receiver and Code Latch

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host sends one word per frame over three wires: an active-low select, a serial clock and a serial data line. An optional fourth wire, an active-low load strobe, can also be used. All of these inputs are asynchronous to the fast system clock. Each one passes through a two-stage synchronizer, and edges are found on the synchronized levels. A shift register collects the bits, most significant first. When select returns high, the frame is judged. With at least 16 captured bits the frame is complete, and the last 16 bits form the word. With fewer bits the frame is short: it is discarded and reported.

A complete word reaches the output code register in one of two ways. In 3-wire mode it is loaded directly. In 4-wire mode it waits as a pending word until the load strobe falls. Every load into the code register gives a one-cycle update pulse. The code register holds zero after reset. The mode input is captured while select is high and frozen for the whole frame. The system clock must run at least four times faster than the serial clock.

The frame controller has two states. FR_IDLE moves to FR_SHIFT on a select fall. FR_SHIFT moves back to FR_IDLE on a select rise and reports either complete or short. The latch controller also has two states. LT_EMPTY moves to LT_PENDING when a complete 4-wire word arrives. LT_PENDING moves back to LT_EMPTY when the strobe falls, or when a complete 3-wire word arrives. LT_PENDING stays in LT_PENDING when a newer 4-wire word arrives, and that newer word replaces the pending one.

Top module: `serdac_frontend`

## Requirements
- R1: After reset the code output is 0x0000, and neither the update pulse nor the short-frame pulse is high.
- R2: In 3-wire mode (`four_wire`=0), a frame of exactly 16 serial clock rises loads the 16 captured bits into the code output when select rises, with the first bit as bit 15 and the last bit as bit 0.
- R3: A frame with fewer than 16 serial clock rises, including none, leaves the code output unchanged, gives no update pulse and gives exactly one short-frame pulse.
- R4: A frame with more than 16 serial clock rises is complete, and the code takes the last 16 bits received.
- R5: In 4-wire mode (`four_wire`=1), a complete frame gives no update when select rises. The next falling edge of the load strobe loads the word.
- R6: A falling load strobe with no pending word changes nothing and gives no update pulse.
- R7: Each load into the code register, in either mode, gives an update pulse that lasts exactly one system clock cycle. The code output changes only in the cycle the update pulse is high.
- R8: The mode is taken from `four_wire` while select is high. A change of `four_wire` during a frame does not affect how that frame is loaded.
- R9: In 4-wire mode, a second complete frame that arrives before the strobe replaces the pending word. The strobe then loads the newer word.
- R10: Serial clock rises that occur while select is high are not counted toward a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| strobe_n | input | 1 | Active-low load strobe for 4-wire mode |
| four_wire | input | 1 | Mode select: 0 = load on select rise, 1 = load on strobe fall |
| dac_code | output | 16 | Latched converter code |
| code_update | output | 1 | One-cycle pulse when `dac_code` is loaded |
| frame_short | output | 1 | One-cycle pulse when a frame closes with too few bits |

## Verification
The assertions assume that a select rise and a serial clock rise never appear in the same synchronized cycle. They also assume that each input holds its level for at least two system clocks, so that every edge is seen once. The stimulus keeps within these limits. It holds each serial clock phase for four system cycles and leaves eight cycles of margin around every select edge. It keeps the load strobe high while data is shifted in and lowers it only after select has returned high.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

    typedef enum logic {
        FR_IDLE  = 1'b0,
        FR_SHIFT = 1'b1
    } frame_st_t;

    typedef enum logic {
        LT_EMPTY   = 1'b0,
        LT_PENDING = 1'b1
    } latch_st_t;

    // Bit positions of the synchronized input bundle
    localparam int IDX_SEL    = 0;
    localparam int IDX_SCK    = 1;
    localparam int IDX_SDI    = 2;
    localparam int IDX_STROBE = 3;
    localparam int IDX_MODE   = 4;
    localparam int N_INPUTS   = 5;

endpackage

// File: rtl/serdac_insync.sv
module serdac_insync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign lvl  = stage_q[STAGES-1];
    assign rise = stage_q[STAGES-1] & ~prev_q;
    assign fall = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/serdac_framer.sv
module serdac_framer
    import serdac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fall,
    input  logic              sel_rise,
    input  logic              sck_rise,
    input  logic              sdi_lvl,
    input  logic              mode_lvl,
    output logic              word_done,
    output logic [DATA_W-1:0] word_data,
    output logic              word_mode,
    output logic              short_err
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    frame_st_t         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mode_frz_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (sel_fall) state_d = FR_SHIFT;
            FR_SHIFT: if (sel_rise) state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            mode_frz_q <= 1'b0;
            word_done  <= 1'b0;
            word_data  <= '0;
            word_mode  <= 1'b0;
            short_err  <= 1'b0;
        end else begin
            word_done <= 1'b0;
            short_err <= 1'b0;
            unique case (state_q)
                FR_IDLE: begin
                    mode_frz_q <= mode_lvl;
                    if (sel_fall) cnt_q <= '0;
                end
                FR_SHIFT: begin
                    if (sck_rise) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], sdi_lvl};
                        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
                    end
                    if (sel_rise) begin
                        if (cnt_q == FULL) begin
                            word_done <= 1'b1;
                            word_data <= shreg_q;
                            word_mode <= mode_frz_q;
                        end else begin
                            short_err <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assert_done_err_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_done && short_err));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    assert_done_closes_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done || short_err) |-> (state_q == FR_IDLE && $past(state_q) == FR_SHIFT));

    assert_idle_no_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_IDLE && !sel_fall) |=> $stable(cnt_q));

endmodule

// File: rtl/serdac_latch.sv
module serdac_latch
    import serdac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_mode,
    input  logic              strobe_fall,
    output logic [DATA_W-1:0] code_q,
    output logic              update_q
);

    latch_st_t         state_q, state_d;
    logic [DATA_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_EMPTY:
                if (word_done && word_mode) state_d = LT_PENDING;
            LT_PENDING:
                if (word_done)        state_d = word_mode ? LT_PENDING : LT_EMPTY;
                else if (strobe_fall) state_d = LT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            pend_q   <= '0;
            update_q <= 1'b0;
        end else begin
            update_q <= 1'b0;
            unique case (state_q)
                LT_EMPTY: begin
                    if (word_done) begin
                        if (word_mode) begin
                            pend_q <= word_data;
                        end else begin
                            code_q   <= word_data;
                            update_q <= 1'b1;
                        end
                    end
                end
                LT_PENDING: begin
                    if (word_done) begin
                        if (word_mode) begin
                            pend_q <= word_data;
                        end else begin
                            code_q   <= word_data;
                            update_q <= 1'b1;
                        end
                    end else if (strobe_fall) begin
                        code_q   <= pend_q;
                        update_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assert_update_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        update_q |=> !update_q);

    assert_code_moves_with_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> update_q);

    assert_empty_strobe_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_EMPTY && strobe_fall && !word_done) |=> !update_q);

    assert_wait_for_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && word_mode) |=> !update_q);

endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
    import serdac_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              strobe_n,
    input  logic              four_wire,
    output logic [DATA_W-1:0] dac_code,
    output logic              code_update,
    output logic              frame_short
);

    // Idle levels: select and strobe released high, others low
    localparam logic [N_INPUTS-1:0] IDLE_LVL =
        N_INPUTS'((1 << IDX_SEL) | (1 << IDX_STROBE));

    logic [N_INPUTS-1:0] raw, lvl, rise, fall;
    logic                done;
    logic [DATA_W-1:0]   word;
    logic                wmode;

    always_comb begin
        raw             = '0;
        raw[IDX_SEL]    = sel_n;
        raw[IDX_SCK]    = sck;
        raw[IDX_SDI]    = sdi;
        raw[IDX_STROBE] = strobe_n;
        raw[IDX_MODE]   = four_wire;
    end

    serdac_insync #(
        .W       (N_INPUTS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LVL)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw),
        .lvl      (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    serdac_framer #(.DATA_W(DATA_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_fall  (fall[IDX_SEL]),
        .sel_rise  (rise[IDX_SEL]),
        .sck_rise  (rise[IDX_SCK]),
        .sdi_lvl   (lvl[IDX_SDI]),
        .mode_lvl  (lvl[IDX_MODE]),
        .word_done (done),
        .word_data (word),
        .word_mode (wmode),
        .short_err (frame_short)
    );

    serdac_latch #(.DATA_W(DATA_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_done   (done),
        .word_data   (word),
        .word_mode   (wmode),
        .strobe_fall (fall[IDX_STROBE]),
        .code_q      (dac_code),
        .update_q    (code_update)
    );

    assert_reset_zero_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (dac_code == '0 && !code_update && !frame_short));

    assert_short_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_short |=> !code_update);

endmodule

// File: tb/serdac_frontend_tb.sv
module serdac_frontend_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        strobe_n = 1'b1;
    logic        four_wire = 1'b0;
    logic [15:0] dac_code;
    logic        code_update;
    logic        frame_short;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    serdac_frontend u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n       (sel_n),
        .sck         (sck),
        .sdi         (sdi),
        .strobe_n    (strobe_n),
        .four_wire   (four_wire),
        .dac_code    (dac_code),
        .code_update (code_update),
        .frame_short (frame_short)
    );

    typedef struct packed {
        logic        four;
        logic [5:0]  nbits;
        logic [31:0] data;
        logic        do_load;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 6'd16, 32'h0000A5C3, 1'b0},
        '{1'b0, 6'd16, 32'h0000FFFF, 1'b0},
        '{1'b0, 6'd8,  32'h000000AB, 1'b0},
        '{1'b0, 6'd20, 32'h000F1234, 1'b0},
        '{1'b1, 6'd16, 32'h00008001, 1'b1},
        '{1'b1, 6'd16, 32'h00007FFE, 1'b0},
        '{1'b1, 6'd16, 32'h00000102, 1'b1},
        '{1'b0, 6'd0,  32'h00000000, 1'b0},
        '{1'b0, 6'd16, 32'h00000000, 1'b0}
    };

    logic [15:0] exp_code = 16'h0000;
    logic        pend_ok  = 1'b0;
    logic [15:0] pend_w   = 16'h0000;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic observe(input int n, output int ups, output int errs,
                           output logic [15:0] code_end);
        ups = 0;
        errs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (code_update) ups++;
            if (frame_short) errs++;
        end
        code_end = dac_code;
    endtask

    // Sends one frame; the last nbits of data go out, MSB first
    task automatic send_frame(input logic four, input int nbits, input logic [31:0] data,
                              input bit flip_mid, input int pre_edges);
        four_wire = four;
        wait_clk(6);
        for (int e = 0; e < pre_edges; e++) begin
            sck = 1'b1; wait_clk(4);
            sck = 1'b0; wait_clk(4);
        end
        sel_n = 1'b0;
        wait_clk(8);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = data[i];
            if (flip_mid && i == nbits / 2) four_wire = ~four;
            wait_clk(4);
            sck = 1'b1; wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(8);
        sel_n = 1'b1;
    endtask

    task automatic pulse_strobe(output int ups, output int errs, output logic [15:0] c);
        strobe_n = 1'b0;
        observe(16, ups, errs, c);
        strobe_n = 1'b1;
        wait_clk(8);
    endtask

    // Applies the expected-result model for one frame and checks it
    task automatic frame_and_check(input logic four, input int nbits, input logic [31:0] data,
                                   input bit do_load, input bit flip_mid, input int pre_edges,
                                   input string tag);
        int ups, errs;
        logic [15:0] c;
        send_frame(four, nbits, data, flip_mid, pre_edges);
        observe(16, ups, errs, c);
        if (nbits < 16) begin
            chk(errs == 1, tag, "short pulse count", errs, 1);
            chk(ups == 0, tag, "update on short frame", ups, 0);
            chk(c == exp_code, tag, "code after short frame", c, exp_code);
        end else if (!four) begin
            exp_code = data[15:0];
            pend_ok  = 1'b0;
            chk(ups == 1, "R7", "update pulse cycles", ups, 1);
            chk(errs == 0, tag, "short pulse on full frame", errs, 0);
            chk(c == exp_code, tag, "code after frame", c, exp_code);
        end else begin
            pend_ok = 1'b1;
            pend_w  = data[15:0];
            chk(ups == 0, "R5", "update at select rise in 4-wire", ups, 0);
            chk(c == exp_code, "R5", "code before strobe", c, exp_code);
        end
        if (do_load) begin
            pulse_strobe(ups, errs, c);
            if (pend_ok) begin
                exp_code = pend_w;
                pend_ok  = 1'b0;
                chk(ups == 1, "R7", "update pulse cycles on strobe", ups, 1);
            end else begin
                chk(ups == 0, "R6", "update on empty strobe", ups, 0);
            end
            chk(c == exp_code, tag, "code after strobe", c, exp_code);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ups, errs;
        logic [15:0] c;
        string tag;

        wait_clk(5);
        chk(dac_code == 16'h0, "R1", "code in reset", dac_code, 0);
        rst_n = 1'b1;
        observe(6, ups, errs, c);
        chk(c == 16'h0, "R1", "code after reset", c, 0);
        chk(ups == 0, "R1", "update after reset", ups, 0);
        chk(errs == 0, "R1", "short pulse after reset", errs, 0);

        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].nbits < 16)                tag = "R3";
            else if (VECS[v].nbits > 16)           tag = "R4";
            else if (VECS[v].four && pend_ok)      tag = "R9";
            else if (VECS[v].four)                 tag = "R5";
            else                                   tag = "R2";
            frame_and_check(VECS[v].four, int'(VECS[v].nbits), VECS[v].data,
                            VECS[v].do_load, 1'b0, 0, tag);
        end

        // R6: strobe with nothing pending
        four_wire = 1'b1;
        wait_clk(6);
        pulse_strobe(ups, errs, c);
        chk(ups == 0, "R6", "update on empty strobe", ups, 0);
        chk(c == exp_code, "R6", "code after empty strobe", c, exp_code);

        // R8: mode flipped to 4-wire mid-frame; the frame still loads at select rise
        frame_and_check(1'b0, 16, 32'h00003C5A, 1'b0, 1'b1, 0, "R8");

        // R10: clock edges before select falls are not counted
        frame_and_check(1'b0, 8, 32'h000000F0, 1'b0, 1'b0, 8, "R10");

        // R10 companion: a full frame after stray edges loads only the framed bits
        frame_and_check(1'b0, 16, 32'h0000BEEF, 1'b0, 1'b0, 5, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule